// File: doc/BRIEF.md
# Descriptor-Table Address Translator

This block converts a logical address, made of a 16-bit segment selector and a 32-bit in-segment offset, into a 32-bit linear address. One selector bit picks the global or the local descriptor table. The upper selector bits index an 8-byte descriptor in that table. The block reads the descriptor from memory, assembles the segment base from it and adds the offset.

A requester presents the selector and offset on a valid/ready request port. The bases and limits of both tables arrive on plain input buses. The block samples those buses, with the request, in the cycle it accepts the request. It first checks the descriptor against the chosen table's limit. If the descriptor fits, it issues two single-word reads on a simple memory port: one request pulse per word, with the reply marked by a valid strobe after any delay. The result is then offered on a response port until it is taken. A descriptor that lies outside its table is reported with a fault flag, and no memory access is made for it.

Top module: `seg_xlate`

## Requirements
- R1: `req_ready` is high only while the block is idle. It goes low in the cycle after a request is accepted and stays low until the result has been taken.
- R2: Selector bit 2 chooses the table. A value of 0 uses `gtbl_base`/`gtbl_limit` and a value of 1 uses `ltbl_base`/`ltbl_limit`.
- R3: The index is selector bits 15:3, and selector bits 1:0 have no effect. The descriptor lives at table base + index × 8, computed modulo 2^32. The first read uses that address and the second read uses that address + 4.
- R4: If index × 8 + 7 is greater than the chosen table's limit, the result has `rsp_fault` = 1 and `rsp_linear` = 0, and no memory read is made. A value exactly equal to the limit is not a fault.
- R5: The two read words hold descriptor bytes 0–3 and 4–7, little-endian (byte n of a word is at bits 8n+7:8n). The segment base is bytes 7, 4, 3, 2 from most to least significant. No other descriptor byte affects the result.
- R6: For a non-faulting request, `rsp_linear` = segment base + offset modulo 2^32, and `rsp_fault` = 0.
- R7: Once `rsp_valid` is high, it stays high and `rsp_linear`/`rsp_fault` stay unchanged until a cycle with `rsp_ready` high. In the next cycle `rsp_valid` is low and `req_ready` is high.
- R8: Each read request is a one-cycle pulse of `mem_rd_en`. Exactly two requests are made per non-faulting translation. The second is not issued until the reply to the first has arrived, whatever the reply latency.
- R9: After reset, `req_ready` = 1, `rsp_valid` = 0 and `mem_rd_en` = 0.
- R10: The selector, offset and both table registers are sampled in the cycle the request is accepted. Later changes to them do not affect the translation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_sel | input | 16 | Segment selector |
| req_off | input | 32 | Offset within the segment |
| gtbl_base | input | 32 | Global table base address |
| gtbl_limit | input | 32 | Global table last valid byte offset |
| ltbl_base | input | 32 | Local table base address |
| ltbl_limit | input | 32 | Local table last valid byte offset |
| mem_rd_en | output | 1 | Read request pulse |
| mem_rd_addr | output | 32 | Read byte address |
| mem_rd_valid | input | 1 | Read reply strobe |
| mem_rd_data | input | 32 | Read reply word |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken |
| rsp_linear | output | 32 | Linear address |
| rsp_fault | output | 1 | Descriptor outside its table |

## Verification
Translations are run through both tables. Each table is paired with a different, unrelated base and limit, so a wrong table choice shows up as a wrong read address or a wrong fault. Selectors use index 0, the largest index and mid-range values, with the two low bits set differently. This separates correct index extraction from shifts that are off by one bit. The offset plus base sometimes crosses 2^32, which exposes a missing wrap. The memory returns distinct pseudo-random words at delays from zero to several cycles, so a base assembled from the wrong bytes, or a read issued before its predecessor returns, gives a mismatch. Limits set exactly at and one below the descriptor's last byte separate an inclusive bound from an exclusive one.

// File: rtl/seg_xlate_pkg.sv
// Shared types for the descriptor-table address translator.
// Assumes byte addressing and a 32-bit memory word.
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        CT_IDLE = 2'd0,
        CT_BUSY = 2'd1,
        CT_DONE = 2'd2
    } ctl_state_t;

    typedef enum logic [2:0] {
        FS_IDLE  = 3'd0,
        FS_ISSUE0 = 3'd1,
        FS_WAIT0 = 3'd2,
        FS_ISSUE1 = 3'd3,
        FS_WAIT1 = 3'd4
    } fetch_state_t;

endpackage

// File: rtl/seg_sel_decode.sv
// Selector decoder: chooses the descriptor table from the table-indicator
// bit, forms the descriptor byte address and flags a descriptor whose last
// byte lies beyond the chosen table's limit.
// Assumes a descriptor of 2**DESC_SHIFT bytes and an index in the selector
// bits above DESC_SHIFT-1. Purely combinational.
module seg_sel_decode #(
    parameter int SEL_W      = 16,
    parameter int AW         = 32,
    parameter int TI_BIT     = 2,
    parameter int DESC_SHIFT = 3
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [AW-1:0]    g_base,
    input  logic [AW-1:0]    g_limit,
    input  logic [AW-1:0]    l_base,
    input  logic [AW-1:0]    l_limit,
    output logic [AW-1:0]    desc_addr,
    output logic             fault
);
    localparam int IDX_W = SEL_W - DESC_SHIFT;
    localparam int PAD_W = AW - SEL_W;

    logic [IDX_W-1:0] idx;
    logic [AW-1:0]    tbl_base;
    logic [AW-1:0]    tbl_limit;
    logic [AW-1:0]    byte_off;
    logic [AW-1:0]    last_byte;

    // Pick the table registers addressed by the indicator bit.
    always_comb begin
        if (sel[TI_BIT]) begin
            tbl_base  = l_base;
            tbl_limit = l_limit;
        end else begin
            tbl_base  = g_base;
            tbl_limit = g_limit;
        end
    end

    // Form descriptor offset, address and bound check.
    always_comb begin
        idx       = sel[SEL_W-1:DESC_SHIFT];
        byte_off  = {{PAD_W{1'b0}}, idx, {DESC_SHIFT{1'b0}}};
        last_byte = {{PAD_W{1'b0}}, idx, {DESC_SHIFT{1'b1}}};
        desc_addr = tbl_base + byte_off;
        fault     = (last_byte > tbl_limit);
    end

endmodule

// File: rtl/seg_desc_fetch.sv
// Descriptor fetcher: on a start pulse reads two consecutive words of a
// descriptor, one request pulse each, waiting for every reply before the
// next request. Raises done for one cycle once both words are held.
// Assumes replies return in request order, one per request.
module seg_desc_fetch #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] desc_addr,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rd_valid,
    input  logic [DW-1:0] mem_rd_data,
    output logic [DW-1:0] word_lo,
    output logic [DW-1:0] word_hi,
    output logic          done
);
    import seg_xlate_pkg::*;

    localparam int WORD_BYTES = DW / 8;

    fetch_state_t  fst;
    logic [AW-1:0] addr_q;

    // Sequence the two reads and capture their replies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fst     <= FS_IDLE;
            addr_q  <= '0;
            word_lo <= '0;
            word_hi <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (fst)
                FS_IDLE: begin
                    if (start) begin
                        addr_q <= desc_addr;
                        fst    <= FS_ISSUE0;
                    end
                end
                FS_ISSUE0: fst <= FS_WAIT0;
                FS_WAIT0: begin
                    if (mem_rd_valid) begin
                        word_lo <= mem_rd_data;
                        fst     <= FS_ISSUE1;
                    end
                end
                FS_ISSUE1: fst <= FS_WAIT1;
                FS_WAIT1: begin
                    if (mem_rd_valid) begin
                        word_hi <= mem_rd_data;
                        done    <= 1'b1;
                        fst     <= FS_IDLE;
                    end
                end
                default: fst <= FS_IDLE;
            endcase
        end
    end

    // Drive the read port from the issue states.
    always_comb begin
        mem_rd_en   = (fst == FS_ISSUE0) || (fst == FS_ISSUE1);
        mem_rd_addr = (fst == FS_ISSUE1) ? addr_q + AW'(WORD_BYTES) : addr_q;
    end

    // R8: a request never lasts more than one cycle.
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R8: no new request while a reply is still outstanding.
    a_r8_wait_reply: assert property (@(posedge clk) disable iff (!rst_n)
        (fst == FS_WAIT0 && !mem_rd_valid) |=> !mem_rd_en);

    // R8: the second request targets the word after the first.
    a_r8_second_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (fst == FS_WAIT0 && mem_rd_valid) |=> (mem_rd_en && mem_rd_addr == addr_q + AW'(WORD_BYTES)));

endmodule

// File: rtl/seg_base_adder.sv
// Base assembler and adder: gathers the segment base from descriptor bytes
// 2, 3, 4 and 7 (byte 2 least significant) of two little-endian words and
// adds the offset modulo 2**AW. Purely combinational.
// Assumes DW = 32 and AW = 32.
module seg_base_adder #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic [DW-1:0] word_lo,
    input  logic [DW-1:0] word_hi,
    input  logic [AW-1:0] offset,
    output logic [AW-1:0] linear
);
    localparam int NB = 2 * DW / 8;

    logic [7:0]    dbyte [NB];
    logic [AW-1:0] seg_base;

    // Split both words into descriptor bytes.
    for (genvar b = 0; b < NB; b++) begin : g_bytes
        if (b < DW / 8) begin : g_lo
            assign dbyte[b] = word_lo[8*b +: 8];
        end else begin : g_hi
            assign dbyte[b] = word_hi[8*(b - DW/8) +: 8];
        end
    end

    // Assemble the base and add the offset.
    always_comb begin
        seg_base = {dbyte[7], dbyte[4], dbyte[3], dbyte[2]};
        linear   = seg_base + offset;
    end

endmodule

// File: rtl/seg_xlate.sv
// Descriptor-table address translator top. Accepts one selector/offset
// request at a time, samples the table registers at acceptance, rejects a
// descriptor beyond its table limit without touching memory, otherwise
// fetches the descriptor and returns base + offset. Holds the result until
// it is taken.
// Assumes the memory port returns exactly one reply per request.
module seg_xlate #(
    parameter int SEL_W      = 16,
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int TI_BIT     = 2,
    parameter int DESC_SHIFT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [SEL_W-1:0] req_sel,
    input  logic [AW-1:0]    req_off,
    input  logic [AW-1:0]    gtbl_base,
    input  logic [AW-1:0]    gtbl_limit,
    input  logic [AW-1:0]    ltbl_base,
    input  logic [AW-1:0]    ltbl_limit,
    output logic             mem_rd_en,
    output logic [AW-1:0]    mem_rd_addr,
    input  logic             mem_rd_valid,
    input  logic [DW-1:0]    mem_rd_data,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [AW-1:0]    rsp_linear,
    output logic             rsp_fault
);
    import seg_xlate_pkg::*;

    ctl_state_t    cst;
    logic [AW-1:0] dec_addr;
    logic          dec_fault;
    logic [AW-1:0] desc_addr_q;
    logic [AW-1:0] off_q;
    logic          start_q;
    logic [DW-1:0] word_lo;
    logic [DW-1:0] word_hi;
    logic          fetch_done;
    logic [AW-1:0] sum_linear;
    logic          accept;

    seg_sel_decode #(
        .SEL_W(SEL_W), .AW(AW), .TI_BIT(TI_BIT), .DESC_SHIFT(DESC_SHIFT)
    ) u_decode (
        .sel       (req_sel),
        .g_base    (gtbl_base),
        .g_limit   (gtbl_limit),
        .l_base    (ltbl_base),
        .l_limit   (ltbl_limit),
        .desc_addr (dec_addr),
        .fault     (dec_fault)
    );

    seg_desc_fetch #(.AW(AW), .DW(DW)) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start_q),
        .desc_addr    (desc_addr_q),
        .mem_rd_en    (mem_rd_en),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .word_lo      (word_lo),
        .word_hi      (word_hi),
        .done         (fetch_done)
    );

    seg_base_adder #(.AW(AW), .DW(DW)) u_adder (
        .word_lo (word_lo),
        .word_hi (word_hi),
        .offset  (off_q),
        .linear  (sum_linear)
    );

    // Handshake decode for the request port.
    always_comb begin
        req_ready = (cst == CT_IDLE);
        rsp_valid = (cst == CT_DONE);
        accept    = req_valid && req_ready;
    end

    // Request sequencing, sampling and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cst         <= CT_IDLE;
            desc_addr_q <= '0;
            off_q       <= '0;
            start_q     <= 1'b0;
            rsp_linear  <= '0;
            rsp_fault   <= 1'b0;
        end else begin
            start_q <= 1'b0;
            case (cst)
                CT_IDLE: begin
                    if (accept) begin
                        desc_addr_q <= dec_addr;
                        off_q       <= req_off;
                        if (dec_fault) begin
                            rsp_linear <= '0;
                            rsp_fault  <= 1'b1;
                            cst        <= CT_DONE;
                        end else begin
                            start_q <= 1'b1;
                            cst     <= CT_BUSY;
                        end
                    end
                end
                CT_BUSY: begin
                    if (fetch_done) begin
                        rsp_linear <= sum_linear;
                        rsp_fault  <= 1'b0;
                        cst        <= CT_DONE;
                    end
                end
                CT_DONE: begin
                    if (rsp_ready) cst <= CT_IDLE;
                end
                default: cst <= CT_IDLE;
            endcase
        end
    end

    // R1: no new request is taken while a result is pending.
    a_r1_busy_while_result: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R1: acceptance drops ready in the next cycle.
    a_r1_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R7: an untaken result holds steady.
    a_r7_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_linear) && $stable(rsp_fault)));

    // R7: a taken result frees the block.
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> (!rsp_valid && req_ready));

    // R4: a faulted result never coincides with memory traffic.
    a_r4_fault_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (!mem_rd_en && rsp_linear == '0));

endmodule

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_sel = '0;
    logic [31:0] req_off = '0;
    logic [31:0] gtbl_base = '0, gtbl_limit = '0, ltbl_base = '0, ltbl_limit = '0;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_linear;
    logic        rsp_fault;

    int tests = 0;
    int fails = 0;

    // memory model state
    int          mem_lat = 0;
    logic        pend = 1'b0;
    int          pcnt = 0;
    logic [31:0] paddr = '0;
    int          rd_cnt = 0;
    logic [31:0] rd_log0 = '0, rd_log1 = '0;
    int          overlap = 0;
    int          wide_pulse = 0;
    logic        last_en = 1'b0;

    always #5 clk = ~clk;

    seg_xlate u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_sel(req_sel), .req_off(req_off),
        .gtbl_base(gtbl_base), .gtbl_limit(gtbl_limit),
        .ltbl_base(ltbl_base), .ltbl_limit(ltbl_limit),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_linear(rsp_linear), .rsp_fault(rsp_fault)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h1234ABCD;
    endfunction

    // Memory model with programmable reply delay, plus request logging.
    always @(posedge clk) begin
        mem_rd_valid <= 1'b0;
        last_en <= mem_rd_en;
        if (mem_rd_en && last_en) wide_pulse <= wide_pulse + 1;
        if (mem_rd_en) begin
            if (pend) overlap <= overlap + 1;
            if (rd_cnt == 0) rd_log0 <= mem_rd_addr;
            if (rd_cnt == 1) rd_log1 <= mem_rd_addr;
            rd_cnt <= rd_cnt + 1;
            pend  <= 1'b1;
            paddr <= mem_rd_addr;
            pcnt  <= mem_lat;
        end else if (pend) begin
            if (pcnt == 0) begin
                mem_rd_valid <= 1'b1;
                mem_rd_data  <= mem_word(paddr);
                pend <= 1'b0;
            end else begin
                pcnt <= pcnt - 1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One full translation with independent expected values.
    task automatic xlate(input string name, input logic [15:0] sel, input logic [31:0] off,
                         input logic [31:0] gb, input logic [31:0] gl,
                         input logic [31:0] lb, input logic [31:0] ll,
                         input int lat, input int hold, input bit disturb);
        logic [31:0] tb_base, tb_lim, daddr, w0, w1, ebase, elin;
        logic [7:0]  by [8];
        logic        efault;
        logic [31:0] hold_lin;
        logic        hold_flt;
        int          guard;
        tb_base = sel[2] ? lb : gb;
        tb_lim  = sel[2] ? ll : gl;
        daddr   = tb_base + 32'(sel[15:3]) * 32'd8;
        efault  = (32'(sel[15:3]) * 32'd8 + 32'd7) > tb_lim;
        w0 = mem_word(daddr);
        w1 = mem_word(daddr + 32'd4);
        for (int i = 0; i < 4; i++) begin
            by[i]   = w0[8*i +: 8];
            by[i+4] = w1[8*i +: 8];
        end
        ebase = {by[7], by[4], by[3], by[2]};
        elin  = efault ? 32'd0 : ebase + off;

        @(negedge clk);
        mem_lat = lat;
        rd_cnt = 0;
        req_sel = sel; req_off = off;
        gtbl_base = gb; gtbl_limit = gl; ltbl_base = lb; ltbl_limit = ll;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check({name, " R1 ready low after accept"}, 32'(req_ready), 32'd0);
        if (disturb) begin
            req_sel = ~sel; req_off = ~off;
            gtbl_base = ~gb; gtbl_limit = 32'd0; ltbl_base = ~lb; ltbl_limit = 32'd0;
        end
        guard = 0;
        while (!rsp_valid && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        check({name, " R1 result arrives"}, 32'(rsp_valid), 32'd1);
        check({name, " R4 fault flag"}, 32'(rsp_fault), 32'(efault));
        check({name, " R6 linear address"}, rsp_linear, elin);
        if (efault) begin
            check({name, " R4 no memory read"}, 32'(rd_cnt), 32'd0);
        end else begin
            check({name, " R8 two reads"}, 32'(rd_cnt), 32'd2);
            check({name, " R3 first read address"}, rd_log0, daddr);
            check({name, " R3 second read address"}, rd_log1, daddr + 32'd4);
        end
        hold_lin = rsp_linear;
        hold_flt = rsp_fault;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            check({name, " R7 result held"}, {rsp_valid, rsp_fault, rsp_linear[29:0]},
                  {1'b1, hold_flt, hold_lin[29:0]});
            check({name, " R1 ready low while held"}, 32'(req_ready), 32'd0);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check({name, " R7 released"}, {31'd0, rsp_valid}, 32'd0);
        check({name, " R1 ready back"}, 32'(req_ready), 32'd1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R9 req_ready after reset", 32'(req_ready), 32'd1);
        check("R9 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        check("R9 mem_rd_en after reset", 32'(mem_rd_en), 32'd0);
    endtask

    task automatic t_global_basic();   // R2 R3 R5 R6
        xlate("global", 16'h0028, 32'h0000_1000, 32'h0010_0000, 32'h0000_FFFF,
              32'h0800_0000, 32'h0000_00FF, 0, 2, 0);
    endtask

    task automatic t_local_lowbits();  // R2 R3: low selector bits ignored
        xlate("local", 16'h0037, 32'h0000_0044, 32'h0010_0000, 32'h0000_0007,
              32'h0A00_0100, 32'h0000_FFFF, 3, 1, 0);
        xlate("local-b", 16'h0034, 32'h0000_0044, 32'h0010_0000, 32'h0000_0007,
              32'h0A00_0100, 32'h0000_FFFF, 1, 0, 0);
    endtask

    task automatic t_wrap();           // R6
        xlate("wrap", 16'h0108, 32'hFFFF_FF00, 32'h0200_0000, 32'hFFFF_FFFF,
              32'h0, 32'h0, 2, 0, 0);
        xlate("wrap-b", 16'h0210, 32'hF0F0_F0F0, 32'h0300_0000, 32'hFFFF_FFFF,
              32'h0, 32'h0, 0, 0, 0);
    endtask

    task automatic t_limits();         // R4
        xlate("limit-exact", 16'h0050, 32'h10, 32'h4000, 32'h0000_0057,
              32'h0, 32'h0, 1, 0, 0);
        xlate("limit-over", 16'h0050, 32'h10, 32'h4000, 32'h0000_0056,
              32'h0, 32'h0, 1, 3, 0);
        xlate("local-fault", 16'h0054, 32'h10, 32'h4000, 32'hFFFF_FFFF,
              32'h8000, 32'h0000_0010, 1, 0, 0);
    endtask

    task automatic t_index_extremes(); // R3
        xlate("index0", 16'h0000, 32'h7, 32'hFFFF_FFF8, 32'h7, 32'h0, 32'h0, 0, 0, 0);
        xlate("indexmax", 16'hFFFB, 32'h1234, 32'h0001_0000, 32'h0000_FFFF,
              32'h0, 32'h0, 5, 0, 0);
    endtask

    task automatic t_sampling();       // R10
        xlate("sampled", 16'h0A0C, 32'h0000_0300, 32'h1000_0000, 32'h0000_0000,
              32'h2000_0000, 32'h0000_FFFF, 4, 1, 1);
        xlate("sampled-fault", 16'h0A08, 32'h0000_0300, 32'h1000_0000, 32'h0000_0000,
              32'h2000_0000, 32'h0000_FFFF, 4, 1, 1);
    endtask

    task automatic t_port_rules();     // R8
        check("R8 no overlapping request", 32'(overlap), 32'd0);
        check("R8 single-cycle pulses", 32'(wide_pulse), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_global_basic();
        t_local_lowbits();
        t_wrap();
        t_limits();
        t_index_extremes();
        t_sampling();
        t_port_rules();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule